// File: doc/BRIEF.md
# Store Set Memory Dependence Predictor

This block decides, at the moment a load or store is fetched, whether that instruction has to wait for an older store that is still in flight. Every instruction starts with no history, so an untrained load is allowed to run ahead of older stores. When the pipeline reports that a load ran early and read stale data, the block ties the load and the store that caused the problem to one shared set identifier. Later fetches of either instruction then look up the set.

Two direct-mapped, untagged tables hold the state. The set table is indexed by instruction address and holds one set identifier per entry. The last-store table is indexed by set identifier and holds the tag of the youngest fetched store of that set that has not yet completed. A fetched load or store reports that tag as its dependence. A fetched store also writes itself into the set's entry. As a result, the stores of a set run in order, and a load waits on all of them through the chain.

A completion port retires last-store entries. A clear input wipes the set table so that stale groupings age out. When a violation involves instructions that already belong to different sets, the sets are merged by a fixed rule.

Top module: `ssp_top`

## Requirements
- R1: After reset, and in the cycle after `clr` is high, no fetch reports a dependence until a violation trains the set table again.
- R2: Both tables are direct-mapped and untagged. The set table is indexed by PC bits [IDX_W+1:2], so two PCs that agree in those bits share one entry.
- R3: A violation where neither the load PC nor the store PC has a valid set gives both entries the identifier formed by the low ID_W bits of the load's set-table index.
- R4: `dep_vld` is high in the same cycle as a fetch exactly when the fetched PC has a valid set and that set's last-store entry is valid, and `dep_tag` then equals the stored tag. Otherwise `dep_vld` is low and `dep_tag` is zero, including in any cycle without a fetch.
- R5: A fetched store whose PC has a valid set writes its `fetch_tag` into that set's last-store entry, visible from the next cycle. A store with no set, and any load, writes nothing.
- R6: A violation where both PCs have valid sets gives both entries the numerically smaller of the two identifiers.
- R7: A violation where only one of the two PCs has a valid set copies that identifier to the other PC's entry.
- R8: A completion whose PC has a valid set invalidates that set's last-store entry only if the entry is valid and holds `cmpl_tag`. A completion with a different tag leaves the entry unchanged.
- R9: When a fetched store writes a last-store entry in the same cycle that a completion would invalidate it, the fetched store's tag remains valid.
- R10: `clr` invalidates every set-table entry and leaves the last-store table untouched. A violation reported in the same cycle as `clr` is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_vld | input | 1 | A load or store is being fetched |
| fetch_is_store | input | 1 | The fetched instruction is a store |
| fetch_pc | input | PC_W | Address of the fetched instruction |
| fetch_tag | input | TAG_W | In-flight tag of the fetched store |
| dep_vld | output | 1 | The fetched instruction must wait on a store |
| dep_tag | output | TAG_W | Tag of the store to wait for |
| cmpl_vld | input | 1 | A store has completed |
| cmpl_pc | input | PC_W | Address of the completed store |
| cmpl_tag | input | TAG_W | Tag of the completed store |
| viol_vld | input | 1 | An ordering violation is reported |
| viol_ld_pc | input | PC_W | Address of the load that ran early |
| viol_st_pc | input | PC_W | Address of the store it bypassed |
| clr | input | 1 | Invalidate the whole set table |

## Verification
The hardest situations to reach from the ports are merges where both instructions already hold different identifiers, and same-cycle collisions between a store fetch and a completion of the set it writes. Without help, random traffic rarely lines these up. The stimulus therefore draws every address from a dozen words plus an aliasing copy one table span higher, and it fires violations, completions and fetches together on most cycles. A directed prologue sets up each merge case, the tag-mismatch completion, the fetch-wins collision and a clear that swallows a violation. A bench-side model of both tables supplies the expected dependence for every cycle.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    // Byte offset bits dropped from an instruction address before indexing
    localparam int WORD_OFS = 2;

    // Which rule decides the identifier written on a violation
    typedef enum logic [1:0] {
        MRG_FRESH   = 2'd0,
        MRG_FROM_LD = 2'd1,
        MRG_FROM_ST = 2'd2,
        MRG_MIN     = 2'd3
    } merge_kind_e;

endpackage

// File: rtl/ssp_set_table.sv
module ssp_set_table #(
    parameter int IDX_W = 6,
    parameter int ID_W  = 4,
    parameter int N_RD  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_a_idx,
    input  logic [IDX_W-1:0] wr_b_idx,
    input  logic [ID_W-1:0]  wr_id,
    input  logic [IDX_W-1:0] rd_idx [N_RD],
    output logic             rd_vld [N_RD],
    output logic [ID_W-1:0]  rd_id  [N_RD]
);
    localparam int DEPTH = 1 << IDX_W;

    typedef struct packed {
        logic            vld;
        logic [ID_W-1:0] id;
    } ent_t;

    typedef struct packed {
        ent_t [DEPTH-1:0] ent;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            for (int i = 0; i < DEPTH; i++) begin
                st_d.ent[i].vld = 1'b0;
            end
        end else if (wr_en) begin
            st_d.ent[wr_a_idx].vld = 1'b1;
            st_d.ent[wr_a_idx].id  = wr_id;
            st_d.ent[wr_b_idx].vld = 1'b1;
            st_d.ent[wr_b_idx].id  = wr_id;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    generate
        for (genvar r = 0; r < N_RD; r++) begin : g_rd
            assign rd_vld[r] = st_q.ent[rd_idx[r]].vld;
            assign rd_id[r]  = st_q.ent[rd_idx[r]].id;
        end
    endgenerate

endmodule

// File: rtl/ssp_last_store.sv
module ssp_last_store #(
    parameter int ID_W  = 4,
    parameter int TAG_W = 6,
    parameter int N_RD  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inv_en,
    input  logic [ID_W-1:0]  inv_id,
    input  logic [TAG_W-1:0] inv_tag,
    input  logic             wr_en,
    input  logic [ID_W-1:0]  wr_id,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [ID_W-1:0]  rd_id  [N_RD],
    output logic             rd_vld [N_RD],
    output logic [TAG_W-1:0] rd_tag [N_RD]
);
    localparam int DEPTH = 1 << ID_W;

    typedef struct packed {
        logic             vld;
        logic [TAG_W-1:0] tag;
    } ent_t;

    typedef struct packed {
        ent_t [DEPTH-1:0] ent;
    } state_t;

    state_t st_d, st_q;
    logic   tag_hit;

    assign tag_hit = st_q.ent[inv_id].vld && (st_q.ent[inv_id].tag == inv_tag);

    always_comb begin
        st_d = st_q;
        // retire first, so a same-cycle write from a younger store survives
        if (inv_en && tag_hit) begin
            st_d.ent[inv_id].vld = 1'b0;
        end
        if (wr_en) begin
            st_d.ent[wr_id].vld = 1'b1;
            st_d.ent[wr_id].tag = wr_tag;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    generate
        for (genvar r = 0; r < N_RD; r++) begin : g_rd
            assign rd_vld[r] = st_q.ent[rd_id[r]].vld;
            assign rd_tag[r] = st_q.ent[rd_id[r]].tag;
        end
    endgenerate

endmodule

// File: rtl/ssp_merge.sv
module ssp_merge #(
    parameter int IDX_W = 6,
    parameter int ID_W  = 4
) (
    input  logic             ld_vld,
    input  logic [ID_W-1:0]  ld_id,
    input  logic             st_vld,
    input  logic [ID_W-1:0]  st_id,
    input  logic [IDX_W-1:0] ld_idx,
    output logic [ID_W-1:0]  out_id
);
    import ssp_pkg::*;

    merge_kind_e kind;
    logic [ID_W-1:0] fresh_id;

    assign fresh_id = ld_idx[ID_W-1:0];

    generate
        if (IDX_W > ID_W) begin : g_spare
            logic unused_idx_hi;
            assign unused_idx_hi = ^ld_idx[IDX_W-1:ID_W];
        end
    endgenerate

    always_comb begin
        if (ld_vld && st_vld) begin
            kind = MRG_MIN;
        end else if (ld_vld) begin
            kind = MRG_FROM_LD;
        end else if (st_vld) begin
            kind = MRG_FROM_ST;
        end else begin
            kind = MRG_FRESH;
        end
    end

    always_comb begin
        unique case (kind)
            MRG_MIN:     out_id = (ld_id < st_id) ? ld_id : st_id;
            MRG_FROM_LD: out_id = ld_id;
            MRG_FROM_ST: out_id = st_id;
            default:     out_id = fresh_id;
        endcase
    end

endmodule

// File: rtl/ssp_top.sv
module ssp_top #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 6,
    parameter int ID_W  = 4,
    parameter int TAG_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fetch_vld,
    input  logic             fetch_is_store,
    input  logic [PC_W-1:0]  fetch_pc,
    input  logic [TAG_W-1:0] fetch_tag,
    output logic             dep_vld,
    output logic [TAG_W-1:0] dep_tag,
    input  logic             cmpl_vld,
    input  logic [PC_W-1:0]  cmpl_pc,
    input  logic [TAG_W-1:0] cmpl_tag,
    input  logic             viol_vld,
    input  logic [PC_W-1:0]  viol_ld_pc,
    input  logic [PC_W-1:0]  viol_st_pc,
    input  logic             clr
);
    localparam int OFS    = ssp_pkg::WORD_OFS;
    localparam int IDX_HI = IDX_W + OFS - 1;
    localparam int RD_F   = 0;
    localparam int RD_C   = 1;
    localparam int RD_L   = 2;
    localparam int RD_S   = 3;
    localparam int N_SRD  = 4;

    logic [IDX_W-1:0] set_rd_idx [N_SRD];
    logic             set_vld    [N_SRD];
    logic [ID_W-1:0]  set_id     [N_SRD];

    logic [ID_W-1:0]  ls_rd_id  [1];
    logic             ls_rd_vld [1];
    logic [TAG_W-1:0] ls_rd_tag [1];

    logic             fetch_set_vld;
    logic             st_wr_en;
    logic             cmpl_inv_en;
    logic [ID_W-1:0]  mrg_id;
    logic             ld_set_vld;
    logic [ID_W-1:0]  ld_set_id;
    logic             st_set_vld;
    logic [ID_W-1:0]  st_set_id;

    logic unused_pc_bits;
    assign unused_pc_bits = ^{fetch_pc[PC_W-1:IDX_HI+1], fetch_pc[OFS-1:0],
                              cmpl_pc[PC_W-1:IDX_HI+1],  cmpl_pc[OFS-1:0],
                              viol_ld_pc[PC_W-1:IDX_HI+1], viol_ld_pc[OFS-1:0],
                              viol_st_pc[PC_W-1:IDX_HI+1], viol_st_pc[OFS-1:0]};

    assign set_rd_idx[RD_F] = fetch_pc[IDX_HI:OFS];
    assign set_rd_idx[RD_C] = cmpl_pc[IDX_HI:OFS];
    assign set_rd_idx[RD_L] = viol_ld_pc[IDX_HI:OFS];
    assign set_rd_idx[RD_S] = viol_st_pc[IDX_HI:OFS];

    assign ld_set_vld = set_vld[RD_L];
    assign ld_set_id  = set_id[RD_L];
    assign st_set_vld = set_vld[RD_S];
    assign st_set_id  = set_id[RD_S];

    ssp_set_table #(
        .IDX_W (IDX_W),
        .ID_W  (ID_W),
        .N_RD  (N_SRD)
    ) u_set (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .wr_en    (viol_vld),
        .wr_a_idx (set_rd_idx[RD_L]),
        .wr_b_idx (set_rd_idx[RD_S]),
        .wr_id    (mrg_id),
        .rd_idx   (set_rd_idx),
        .rd_vld   (set_vld),
        .rd_id    (set_id)
    );

    ssp_merge #(
        .IDX_W (IDX_W),
        .ID_W  (ID_W)
    ) u_merge (
        .ld_vld (ld_set_vld),
        .ld_id  (ld_set_id),
        .st_vld (st_set_vld),
        .st_id  (st_set_id),
        .ld_idx (set_rd_idx[RD_L]),
        .out_id (mrg_id)
    );

    assign fetch_set_vld = fetch_vld && set_vld[RD_F];
    assign st_wr_en      = fetch_set_vld && fetch_is_store;
    assign cmpl_inv_en   = cmpl_vld && set_vld[RD_C];
    assign ls_rd_id[0]   = set_id[RD_F];

    ssp_last_store #(
        .ID_W  (ID_W),
        .TAG_W (TAG_W),
        .N_RD  (1)
    ) u_last (
        .clk     (clk),
        .rst_n   (rst_n),
        .inv_en  (cmpl_inv_en),
        .inv_id  (set_id[RD_C]),
        .inv_tag (cmpl_tag),
        .wr_en   (st_wr_en),
        .wr_id   (set_id[RD_F]),
        .wr_tag  (fetch_tag),
        .rd_id   (ls_rd_id),
        .rd_vld  (ls_rd_vld),
        .rd_tag  (ls_rd_tag)
    );

    assign dep_vld = fetch_set_vld && ls_rd_vld[0];
    assign dep_tag = dep_vld ? ls_rd_tag[0] : '0;

endmodule

// File: rtl/ssp_checker.sv
module ssp_checker #(
    parameter int PC_W  = 32,
    parameter int ID_W  = 4,
    parameter int TAG_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr,
    input logic             viol_vld,
    input logic             fetch_vld,
    input logic             fetch_is_store,
    input logic [PC_W-1:0]  fetch_pc,
    input logic [TAG_W-1:0] fetch_tag,
    input logic             dep_vld,
    input logic [TAG_W-1:0] dep_tag,
    input logic             fset_vld,
    input logic [ID_W-1:0]  mrg_id,
    input logic             ld_set_vld,
    input logic [ID_W-1:0]  ld_set_id,
    input logic             st_set_vld,
    input logic [ID_W-1:0]  st_set_id
);

    // R1: the set table is empty in the cycle after a clear
    a_r1_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !dep_vld);

    // R4: no dependence is reported without a fetch
    a_r4_dep_needs_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_vld |-> (!dep_vld && dep_tag == '0));

    // R5: a store of a set, refetched next cycle, waits on its previous copy
    a_r5_store_chain: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_vld && $past(fset_vld && fetch_is_store && !clr && !viol_vld)
         && fetch_pc == $past(fetch_pc))
        |-> (dep_vld && dep_tag == $past(fetch_tag)));

    // R6: merging two valid sets keeps the smaller identifier
    a_r6_merge_min: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_vld && ld_set_vld && st_set_vld)
        |-> (mrg_id <= ld_set_id && mrg_id <= st_set_id
             && (mrg_id == ld_set_id || mrg_id == st_set_id)));

    // R7: a single valid identifier is copied across
    a_r7_merge_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_vld && (ld_set_vld != st_set_vld))
        |-> (mrg_id == (ld_set_vld ? ld_set_id : st_set_id)));

endmodule

bind ssp_top ssp_checker #(
    .PC_W  (PC_W),
    .ID_W  (ID_W),
    .TAG_W (TAG_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .clr            (clr),
    .viol_vld       (viol_vld),
    .fetch_vld      (fetch_vld),
    .fetch_is_store (fetch_is_store),
    .fetch_pc       (fetch_pc),
    .fetch_tag      (fetch_tag),
    .dep_vld        (dep_vld),
    .dep_tag        (dep_tag),
    .fset_vld       (fetch_set_vld),
    .mrg_id         (mrg_id),
    .ld_set_vld     (ld_set_vld),
    .ld_set_id      (ld_set_id),
    .st_set_vld     (st_set_vld),
    .st_set_id      (st_set_id)
);

// File: tb/sim_ssp_top.sv
module sim_ssp_top;
    localparam int PC_W  = 32;
    localparam int IDX_W = 6;
    localparam int ID_W  = 4;
    localparam int TAG_W = 6;
    localparam int NSET  = 1 << IDX_W;
    localparam int NID   = 1 << ID_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             fetch_vld = 1'b0;
    logic             fetch_is_store = 1'b0;
    logic [PC_W-1:0]  fetch_pc = '0;
    logic [TAG_W-1:0] fetch_tag = '0;
    logic             dep_vld;
    logic [TAG_W-1:0] dep_tag;
    logic             cmpl_vld = 1'b0;
    logic [PC_W-1:0]  cmpl_pc = '0;
    logic [TAG_W-1:0] cmpl_tag = '0;
    logic             viol_vld = 1'b0;
    logic [PC_W-1:0]  viol_ld_pc = '0;
    logic [PC_W-1:0]  viol_st_pc = '0;
    logic             clr = 1'b0;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // bench-side table contents
    bit               m_sv [NSET];
    logic [ID_W-1:0]  m_sid[NSET];
    bit               m_lv [NID];
    logic [TAG_W-1:0] m_lt [NID];

    always #4 clk = ~clk;

    ssp_top #(.PC_W(PC_W), .IDX_W(IDX_W), .ID_W(ID_W), .TAG_W(TAG_W)) u0 (
        .clk(clk), .rst_n(rst_n),
        .fetch_vld(fetch_vld), .fetch_is_store(fetch_is_store),
        .fetch_pc(fetch_pc), .fetch_tag(fetch_tag),
        .dep_vld(dep_vld), .dep_tag(dep_tag),
        .cmpl_vld(cmpl_vld), .cmpl_pc(cmpl_pc), .cmpl_tag(cmpl_tag),
        .viol_vld(viol_vld), .viol_ld_pc(viol_ld_pc), .viol_st_pc(viol_st_pc),
        .clr(clr)
    );

    function automatic int pidx(input logic [PC_W-1:0] pc);
        return int'(pc[IDX_W+1:2]);
    endfunction

    // identifier chosen on a violation (R3, R6, R7)
    function automatic logic [ID_W-1:0] pick_id(input int li, input int si);
        if (m_sv[li] && m_sv[si]) return (m_sid[li] < m_sid[si]) ? m_sid[li] : m_sid[si];
        if (m_sv[li]) return m_sid[li];
        if (m_sv[si]) return m_sid[si];
        return li[ID_W-1:0];
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NSET; i++) begin m_sv[i] = 1'b0; m_sid[i] = '0; end
        for (int i = 0; i < NID; i++)  begin m_lv[i] = 1'b0; m_lt[i] = '0; end
    endtask

    task automatic step(input string req,
                        input bit fv, input bit fst, input logic [PC_W-1:0] fpc, input logic [TAG_W-1:0] ftag,
                        input bit cv, input logic [PC_W-1:0] cpc, input logic [TAG_W-1:0] ctag,
                        input bit vv, input logic [PC_W-1:0] lpc, input logic [PC_W-1:0] spc,
                        input bit kc);
        int fi, ci, li, si;
        bit ev;
        logic [TAG_W-1:0] et;
        logic [ID_W-1:0] nid;
        @(negedge clk);
        fetch_vld = fv; fetch_is_store = fst; fetch_pc = fpc; fetch_tag = ftag;
        cmpl_vld = cv; cmpl_pc = cpc; cmpl_tag = ctag;
        viol_vld = vv; viol_ld_pc = lpc; viol_st_pc = spc; clr = kc;
        fi = pidx(fpc); ci = pidx(cpc); li = pidx(lpc); si = pidx(spc);
        ev = fv && m_sv[fi] && m_lv[m_sid[fi]];
        et = ev ? m_lt[m_sid[fi]] : '0;
        #2;
        n_chk++;
        if (dep_vld !== ev || dep_tag !== et) begin
            n_fail++;
            $display("FAIL %s: dep_vld/dep_tag = %0b/%0d, expected %0b/%0d (pc %h)",
                     req, dep_vld, dep_tag, ev, et, fpc);
        end
        @(posedge clk);
        nid = pick_id(li, si);
        if (cv && m_sv[ci] && m_lv[m_sid[ci]] && m_lt[m_sid[ci]] == ctag) m_lv[m_sid[ci]] = 1'b0;
        if (fv && fst && m_sv[fi]) begin m_lv[m_sid[fi]] = 1'b1; m_lt[m_sid[fi]] = ftag; end
        if (kc) begin
            for (int i = 0; i < NSET; i++) m_sv[i] = 1'b0;
        end else if (vv) begin
            m_sv[li] = 1'b1; m_sid[li] = nid;
            m_sv[si] = 1'b1; m_sid[si] = nid;
        end
    endtask

    task automatic fet(input string req, input bit st, input logic [PC_W-1:0] pc, input logic [TAG_W-1:0] tag);
        step(req, 1'b1, st, pc, tag, 1'b0, '0, '0, 1'b0, '0, '0, 1'b0);
    endtask

    task automatic vio(input string req, input logic [PC_W-1:0] lpc, input logic [PC_W-1:0] spc);
        step(req, 1'b0, 1'b0, '0, '0, 1'b0, '0, '0, 1'b1, lpc, spc, 1'b0);
    endtask

    task automatic cmp(input string req, input logic [PC_W-1:0] pc, input logic [TAG_W-1:0] tag);
        step(req, 1'b0, 1'b0, '0, '0, 1'b1, pc, tag, 1'b0, '0, '0, 1'b0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    localparam logic [PC_W-1:0] LD_A = 32'h44;
    localparam logic [PC_W-1:0] LD_B = 32'h58;
    localparam logic [PC_W-1:0] LD_C = 32'h64;
    localparam logic [PC_W-1:0] ST_A = 32'h200;
    localparam logic [PC_W-1:0] ST_B = 32'h2A0;

    initial begin
        void'($urandom(32'd4242));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: empty after reset, untrained fetches run free
        step("R1", 1'b0, 1'b0, '0, '0, 1'b0, '0, '0, 1'b0, '0, '0, 1'b0);
        fet("R1", 1'b1, ST_A, 6'd5);
        fet("R1", 1'b0, LD_A, '0);
        // R3: fresh set, then the chain through the last-store table (R5)
        vio("R3", LD_A, ST_A);
        fet("R5", 1'b1, ST_A, 6'd7);
        fet("R3", 1'b0, LD_A, '0);
        fet("R2", 1'b0, LD_A + 32'h100, '0);
        fet("R2", 1'b0, LD_A + 32'h4, '0);
        fet("R5", 1'b0, LD_B, '0);
        // R8: mismatched tag ignored, matching tag retires
        cmp("R8", ST_A, 6'd3);
        fet("R8", 1'b0, LD_A, '0);
        cmp("R8", ST_A, 6'd7);
        fet("R8", 1'b0, LD_A, '0);
        // R9: younger store write survives same-cycle retire
        fet("R9", 1'b1, ST_A, 6'd10);
        step("R9", 1'b1, 1'b1, ST_A, 6'd11, 1'b1, ST_A, 6'd10, 1'b0, '0, '0, 1'b0);
        fet("R9", 1'b0, LD_A, '0);
        // R7: a new load joins an existing set
        vio("R3", LD_B, ST_B);
        vio("R7", LD_C, ST_A);
        fet("R7", 1'b1, ST_A, 6'd12);
        fet("R7", 1'b0, LD_C, '0);
        // R6: two populated sets merge onto the smaller id
        vio("R6", LD_A, ST_B);
        fet("R6", 1'b1, ST_B, 6'd13);
        fet("R6", 1'b0, LD_A, '0);
        fet("R6", 1'b0, LD_B, '0);
        // R10: clear with a coincident violation, last-store table kept
        step("R10", 1'b0, 1'b0, '0, '0, 1'b0, '0, '0, 1'b1, LD_B, ST_A, 1'b1);
        fet("R10", 1'b0, LD_A, '0);
        fet("R10", 1'b0, LD_B, '0);
        fet("R10", 1'b1, ST_A, 6'd14);
        vio("R10", LD_A, ST_B);
        fet("R10", 1'b0, LD_A, '0);

        // mixed random traffic over a small, aliasing address pool
        for (int n = 0; n < 6000; n++) begin
            logic [PC_W-1:0] p0, p1, p2, p3;
            p0 = (($urandom % 12) << 2) | ((($urandom % 4) == 0) ? 32'h100 : 32'h0);
            p1 = (($urandom % 12) << 2) | ((($urandom % 4) == 0) ? 32'h100 : 32'h0);
            p2 = (($urandom % 12) << 2) | ((($urandom % 4) == 0) ? 32'h100 : 32'h0);
            p3 = (($urandom % 12) << 2) | ((($urandom % 4) == 0) ? 32'h100 : 32'h0);
            step("R4",
                 ($urandom % 4) != 0, $urandom % 2, p0, TAG_W'($urandom),
                 ($urandom % 3) == 0, p1, TAG_W'($urandom % 8),
                 ($urandom % 6) == 0, p2, p3,
                 ($urandom % 400) == 0);
        end

        @(negedge clk);
        fetch_vld = 1'b0; cmpl_vld = 1'b0; viol_vld = 1'b0; clr = 1'b0;
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not end, actual timeout expected completion");
        finish_run();
    end

endmodule